// File: doc/BRIEF.md
# PCI Slot Hotplug Controller

This block keeps the hotplug bookkeeping for a bank of PCI slots, one bit per slot, and firmware reaches it through a small window of 32-bit registers. It holds three per-slot masks: devices present, removals pending and slots that may be hot-plugged. Platform logic reports three kinds of event, each with a slot index. An insertion marks the slot present. A removal request marks the slot as awaiting ejection. A boot-time (coldplug) presence report marks the slot present and raises nothing. Insertions and removal requests set a general-purpose event status bit, and that bit drives an interrupt when firmware has enabled it.

Firmware reads the "up" view, which is presence masked by hotplug capability. It reads the pending-removal view and the capability view. It writes the eject register to finish a removal. The state machine has three states. ST_IDLE serves events and accesses. A platform reset pulse moves it to ST_DRAIN when removals are pending, or to ST_REBUILD when none are. ST_DRAIN executes one pending removal per cycle and moves to ST_REBUILD once the last one is done. ST_REBUILD reloads the capability mask from the fixed-function indication and the presence mask from the populated indication, then returns to ST_IDLE. Hardware reset enters ST_REBUILD.

Top module: `hp_slot_ctrl`

## Requirements
- R1: An access is decoded only when acc_size is 4 and acc_addr is 0x00 (up), 0x04 (down), 0x08 (eject/features), 0x0C (removable), 0x10 (event status) or 0x14 (event enable). A read registers its data into acc_rdata on the clock edge that samples it. A read that is not decoded returns 0. A write that is not decoded has no effect.
- R2: A read of 0x00 returns the present mask ANDed with the capable mask.
- R3: A read of 0x04 returns the pending-removal mask. A read of 0x0C returns the capable mask. Writes to 0x00, 0x04 and 0x0C change nothing.
- R4: A write to 0x08 in ST_IDLE ejects only the lowest-numbered set bit of the written value. That slot's pending bit clears. Its present bit clears only when fixed_mask for that slot is 0. A write of zero does nothing.
- R5: A read of 0x08 returns the feature word 0.
- R6: In ST_IDLE an insert event sets the slot's present bit, and a removal request sets its pending bit. Either one sets event status bit 1 (value 0x2).
- R7: A coldplug event sets the slot's present bit and leaves event status unchanged.
- R8: Event status at 0x10 is write-1-to-clear. Event enable at 0x14 is read/write, 8 bits. evt_irq is high while status AND enable is nonzero.
- R9: A plat_reset pulse in ST_IDLE keeps busy high for (number of pending removals + 1) cycles. One pending removal is executed per cycle. Then capable becomes ~fixed_mask, present becomes populated_mask and pending becomes 0. While busy, events and eject writes are ignored.
- R10: After hardware reset, busy is high for one cycle. Then capable is ~fixed_mask and present is populated_mask. Pending, status, enable, acc_rdata and evt_irq are all 0.
- R11: When two actions fall in the same cycle, the new event wins. A removal request in the same cycle as an eject of that slot leaves the pending bit set. An insert in the same cycle as an eject of that slot leaves it present. An event in the same cycle as a status clear leaves status bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset of the access |
| acc_size | input | 3 | Access width in bytes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| ins_valid | input | 1 | Hotplug insert event |
| ins_slot | input | 5 | Slot of the insert event |
| rem_valid | input | 1 | Removal request event |
| rem_slot | input | 5 | Slot of the removal request |
| cold_valid | input | 1 | Coldplug presence event |
| cold_slot | input | 5 | Slot of the coldplug event |
| fixed_mask | input | 32 | Slots holding a non-hotpluggable function |
| populated_mask | input | 32 | Slots physically populated |
| plat_reset | input | 1 | Platform reset pulse |
| busy | output | 1 | Reset sequence in progress |
| evt_irq | output | 1 | Event interrupt |

## Verification
An eject write and a fresh event for the same slot can land in one clock. Likewise, an event can coincide with a status clear. The bench provokes this by driving the eject write and a removal request for the same slot in a single cycle. It then drives an eject together with an insert, and finally a status clear together with an insert. It judges each case by reading back the pending, up and status registers: the new event must survive.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_REBUILD} hp_state_e;
    typedef enum logic [2:0] {REG_NONE, REG_UP, REG_DOWN, REG_EJECT, REG_RMV, REG_STS, REG_EN} hp_reg_e;
    localparam logic [4:0] OFF_UP    = 5'h00;
    localparam logic [4:0] OFF_DOWN  = 5'h04;
    localparam logic [4:0] OFF_EJECT = 5'h08;
    localparam logic [4:0] OFF_RMV   = 5'h0C;
    localparam logic [4:0] OFF_STS   = 5'h10;
    localparam logic [4:0] OFF_EN    = 5'h14;
    localparam int ACC_BYTES = 4;
    localparam int EVT_BIT   = 1;
endpackage

// File: rtl/hp_slot_decode.sv
module hp_slot_decode
    import hp_slot_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int SIZE_W = 3
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    output hp_reg_e           reg_id,
    output logic              rd_en,
    output logic              wr_en
);
    always_comb begin
        reg_id = REG_NONE;
        if (acc_valid && acc_size == SIZE_W'(ACC_BYTES)) begin
            case (acc_addr)
                ADDR_W'(OFF_UP):    reg_id = REG_UP;
                ADDR_W'(OFF_DOWN):  reg_id = REG_DOWN;
                ADDR_W'(OFF_EJECT): reg_id = REG_EJECT;
                ADDR_W'(OFF_RMV):   reg_id = REG_RMV;
                ADDR_W'(OFF_STS):   reg_id = REG_STS;
                ADDR_W'(OFF_EN):    reg_id = REG_EN;
                default:            reg_id = REG_NONE;
            endcase
        end
        rd_en = (reg_id != REG_NONE) && !acc_write;
        wr_en = (reg_id != REG_NONE) && acc_write;
    end
endmodule

// File: rtl/hp_slot_lowbit.sv
module hp_slot_lowbit #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vec,
    output logic [W-1:0] onehot,
    output logic         any
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (g == 0) begin : g_first
            assign onehot[g] = vec[g];
        end else begin : g_rest
            assign onehot[g] = vec[g] & ~(|vec[g-1:0]);
        end
    end
    assign any = |vec;

    // R4: only one slot is ever picked for ejection
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(onehot) && (any == (onehot != '0)));
endmodule

// File: rtl/hp_slot_gpe.sv
module hp_slot_gpe
    import hp_slot_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_evt,
    input  logic          sts_wr,
    input  logic          en_wr,
    input  logic [EW-1:0] wdata,
    output logic [EW-1:0] sts,
    output logic [EW-1:0] en,
    output logic          irq
);
    logic [EW-1:0] clr_bits;
    logic [EW-1:0] set_bits;

    assign clr_bits = sts_wr ? wdata : '0;
    assign set_bits = set_evt ? EW'(1 << EVT_BIT) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
            en  <= '0;
        end else begin
            sts <= (sts & ~clr_bits) | set_bits;
            if (en_wr) en <= wdata;
        end
    end

    assign irq = |(sts & en);

    // R11: a new event survives a same-cycle clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> sts[EVT_BIT]);
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int SIZE_W = 3,
    parameter int EVT_W  = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SIZE_W-1:0] acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              ins_valid,
    input  logic [SLOT_W-1:0] ins_slot,
    input  logic              rem_valid,
    input  logic [SLOT_W-1:0] rem_slot,
    input  logic              cold_valid,
    input  logic [SLOT_W-1:0] cold_slot,
    input  logic [SLOTS-1:0]  fixed_mask,
    input  logic [SLOTS-1:0]  populated_mask,
    input  logic              plat_reset,
    output logic              busy,
    output logic              evt_irq
);
    hp_state_e        state_q, state_n;
    logic [SLOTS-1:0] present_q, present_n;
    logic [SLOTS-1:0] down_q, down_n;
    logic [SLOTS-1:0] cap_q, cap_n;
    logic [SLOTS-1:0] low_in, sel;
    logic             sel_any;
    logic [SLOTS-1:0] ins_oh, rem_oh, cold_oh;
    logic             idle, eject_do;
    hp_reg_e          reg_id;
    logic             rd_en, wr_en;
    logic [EVT_W-1:0] gpe_sts, gpe_en;

    hp_slot_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_decode (
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_size(acc_size), .reg_id(reg_id), .rd_en(rd_en), .wr_en(wr_en)
    );

    assign idle   = (state_q == ST_IDLE);
    assign low_in = (state_q == ST_DRAIN) ? down_q : acc_wdata[SLOTS-1:0];

    hp_slot_lowbit #(.W(SLOTS)) u_lowbit (
        .clk(clk), .rst_n(rst_n), .vec(low_in), .onehot(sel), .any(sel_any)
    );

    assign eject_do = (state_q == ST_DRAIN) ||
                      (idle && wr_en && reg_id == REG_EJECT && sel_any);
    assign ins_oh  = (idle && ins_valid)  ? (SLOTS'(1) << ins_slot)  : '0;
    assign rem_oh  = (idle && rem_valid)  ? (SLOTS'(1) << rem_slot)  : '0;
    assign cold_oh = (idle && cold_valid) ? (SLOTS'(1) << cold_slot) : '0;

    hp_slot_gpe #(.EW(EVT_W)) u_gpe (
        .clk(clk), .rst_n(rst_n),
        .set_evt(idle && (ins_valid || rem_valid)),
        .sts_wr(wr_en && reg_id == REG_STS),
        .en_wr(wr_en && reg_id == REG_EN),
        .wdata(acc_wdata[EVT_W-1:0]),
        .sts(gpe_sts), .en(gpe_en), .irq(evt_irq)
    );

    // next-state process
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (plat_reset) state_n = (down_q != '0) ? ST_DRAIN : ST_REBUILD;
            ST_DRAIN:   if ((down_q & ~sel) == '0) state_n = ST_REBUILD;
            ST_REBUILD: state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_REBUILD;
        else        state_q <= state_n;
    end

    // mask update and outputs
    always_comb begin
        present_n = present_q;
        down_n    = down_q;
        cap_n     = cap_q;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DRAIN: begin
                busy = (state_q == ST_DRAIN);
                if (eject_do) begin
                    down_n    = down_n & ~sel;
                    present_n = present_n & ~(sel & ~fixed_mask);
                end
                present_n = present_n | ins_oh | cold_oh;
                down_n    = down_n | rem_oh;
            end
            ST_REBUILD: begin
                busy      = 1'b1;
                cap_n     = ~fixed_mask;
                present_n = populated_mask;
                down_n    = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present_q <= '0;
            down_q    <= '0;
            cap_q     <= '1;
            acc_rdata <= '0;
        end else begin
            present_q <= present_n;
            down_q    <= down_n;
            cap_q     <= cap_n;
            if (acc_valid && !acc_write) begin
                acc_rdata <= '0;
                if (rd_en) begin
                    case (reg_id)
                        REG_UP:   acc_rdata <= DATA_W'(present_q & cap_q);
                        REG_DOWN: acc_rdata <= DATA_W'(down_q);
                        REG_RMV:  acc_rdata <= DATA_W'(cap_q);
                        REG_STS:  acc_rdata <= DATA_W'(gpe_sts);
                        REG_EN:   acc_rdata <= DATA_W'(gpe_en);
                        default:  acc_rdata <= '0;
                    endcase
                end
            end
        end
    end

    // R6: an insert marks the slot present
    p_ins_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && ins_valid) |=> present_q[$past(ins_slot)]);

    // R7: coldplug alone raises no event status
    p_cold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cold_valid && !ins_valid && !rem_valid && gpe_sts == '0)
        |=> gpe_sts == '0);

    // R9: each drain cycle retires exactly one pending removal
    p_drain_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> $countones(down_q) == $countones($past(down_q)) - 1);

    // R4: an eject without a competing request clears the chosen pending bit
    p_eject_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && wr_en && reg_id == REG_EJECT && sel_any && !rem_valid)
        |=> (down_q & $past(sel)) == '0);
endmodule

// File: tb/hp_slot_ctrl_bench.sv
module hp_slot_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_write = 0;
    logic [4:0]  acc_addr = 0;
    logic [2:0]  acc_size = 0;
    logic [31:0] acc_wdata = 0, acc_rdata;
    logic        ins_valid = 0, rem_valid = 0, cold_valid = 0;
    logic [4:0]  ins_slot = 0, rem_slot = 0, cold_slot = 0;
    logic [31:0] fixed_mask = 32'h10, populated_mask = 32'h31;
    logic        plat_reset = 0, busy, evt_irq;
    int          n_checks = 0, n_fails = 0;

    always #2 clk = ~clk;

    hp_slot_ctrl u_hp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .ins_valid(ins_valid), .ins_slot(ins_slot),
        .rem_valid(rem_valid), .rem_slot(rem_slot), .cold_valid(cold_valid),
        .cold_slot(cold_slot), .fixed_mask(fixed_mask), .populated_mask(populated_mask),
        .plat_reset(plat_reset), .busy(busy), .evt_irq(evt_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic acc_set(input logic wr, input logic [4:0] a, input logic [31:0] d, input logic [2:0] sz);
        acc_valid = 1; acc_write = wr; acc_addr = a; acc_wdata = d; acc_size = sz;
    endtask

    task automatic acc_clr;
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [2:0] sz, output logic [31:0] d);
        acc_set(0, a, 0, sz); tick; acc_clr; d = acc_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [2:0] sz);
        acc_set(1, a, d, sz); tick; acc_clr;
    endtask

    task automatic rchk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, 3'd4, d);
        chk(req, d, exp);
    endtask

    task automatic ev_ins(input logic [4:0] s);
        ins_valid = 1; ins_slot = s; tick; ins_valid = 0;
    endtask

    task automatic ev_rem(input logic [4:0] s);
        rem_valid = 1; rem_slot = s; tick; rem_valid = 0;
    endtask

    task automatic ev_cold(input logic [4:0] s);
        cold_valid = 1; cold_slot = s; tick; cold_valid = 0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R10 busy after reset", {31'b0, busy}, 1);
        chk("R10 rdata reset", acc_rdata, 0);
        chk("R10 irq reset", {31'b0, evt_irq}, 0);
        tick;
        chk("R10 busy drops", {31'b0, busy}, 0);
        rchk("R10 up after rebuild (R2)", 5'h00, 32'h21);
        rchk("R10 removable = ~fixed", 5'h0C, 32'hFFFF_FFEF);
        rchk("R10 down clear", 5'h04, 0);
        rchk("R10 status clear", 5'h10, 0);
        rchk("R10 enable clear", 5'h14, 0);
    endtask

    task automatic t_decode;
        logic [31:0] d;
        rd(5'h00, 3'd2, d);
        chk("R1 short read ignored", d, 0);
        rd(5'h18, 3'd4, d);
        chk("R1 bad offset read", d, 0);
        wr(5'h14, 32'h2, 3'd1);
        rchk("R1 short write ignored", 5'h14, 0);
        rchk("R5 feature word", 5'h08, 0);
    endtask

    task automatic t_readonly;
        wr(5'h00, 32'hFFFF_FFFF, 3'd4);
        wr(5'h04, 32'hFFFF_FFFF, 3'd4);
        wr(5'h0C, 32'h0, 3'd4);
        rchk("R3 up unchanged by write", 5'h00, 32'h21);
        rchk("R3 down unchanged by write", 5'h04, 0);
        rchk("R3 removable unchanged by write", 5'h0C, 32'hFFFF_FFEF);
    endtask

    task automatic t_insert_cold;
        ev_ins(9);
        rchk("R6 insert up", 5'h00, 32'h221);
        rchk("R6 insert status", 5'h10, 32'h2);
        wr(5'h10, 32'h2, 3'd4);
        rchk("R8 status w1c", 5'h10, 0);
        ev_cold(12);
        rchk("R7 cold up", 5'h00, 32'h1221);
        rchk("R7 cold no status", 5'h10, 0);
    endtask

    task automatic t_irq;
        wr(5'h14, 32'h2, 3'd4);
        chk("R8 irq idle", {31'b0, evt_irq}, 0);
        ev_rem(5);
        chk("R8 irq raised", {31'b0, evt_irq}, 1);
        rchk("R6 remove down", 5'h04, 32'h20);
        rchk("R6 remove status", 5'h10, 32'h2);
        wr(5'h10, 32'h0, 3'd4);
        rchk("R8 w1c of zero keeps", 5'h10, 32'h2);
        wr(5'h10, 32'h2, 3'd4);
        chk("R8 irq cleared", {31'b0, evt_irq}, 0);
    endtask

    task automatic t_eject;
        ev_rem(9);
        wr(5'h08, 32'h220, 3'd4);
        rchk("R4 lowest bit ejected down", 5'h04, 32'h200);
        rchk("R4 lowest bit ejected up", 5'h00, 32'h1201);
        wr(5'h08, 32'h0, 3'd4);
        rchk("R4 zero eject ignored", 5'h04, 32'h200);
        wr(5'h08, 32'h200, 3'd4);
        rchk("R4 second eject up", 5'h00, 32'h1001);
        fixed_mask = 32'h80;
        ev_ins(7);
        ev_rem(7);
        wr(5'h08, 32'h80, 3'd4);
        rchk("R4 fixed eject down", 5'h04, 0);
        rchk("R4 fixed slot stays present", 5'h00, 32'h1081);
        fixed_mask = 32'h10;
        wr(5'h10, 32'hFF, 3'd4);
    endtask

    task automatic t_same_cycle;
        ev_rem(3);
        rem_valid = 1; rem_slot = 3; acc_set(1, 5'h08, 32'h8, 3'd4);
        tick; rem_valid = 0; acc_clr;
        rchk("R11 request beats eject", 5'h04, 32'h8);
        ins_valid = 1; ins_slot = 3; acc_set(1, 5'h08, 32'h8, 3'd4);
        tick; ins_valid = 0; acc_clr;
        rchk("R11 insert beats eject", 5'h00, 32'h1089);
        rchk("R11 eject done", 5'h04, 0);
        wr(5'h10, 32'hFF, 3'd4);
        ins_valid = 1; ins_slot = 3; acc_set(1, 5'h10, 32'h2, 3'd4);
        tick; ins_valid = 0; acc_clr;
        rchk("R11 event beats clear", 5'h10, 32'h2);
    endtask

    task automatic t_plat;
        int n;
        n = 0;
        ev_rem(0);
        ev_rem(9);
        wr(5'h10, 32'hFF, 3'd4);
        plat_reset = 1; tick; plat_reset = 0;
        while (busy && n < 100) begin
            n++;
            if (n == 1) begin ins_valid = 1; ins_slot = 20; end
            tick;
            ins_valid = 0;
        end
        chk("R9 busy length", n, 3);
        rchk("R9 status untouched while busy", 5'h10, 0);
        rchk("R9 up rebuilt", 5'h00, 32'h21);
        rchk("R9 down drained", 5'h04, 0);
        rchk("R9 removable rebuilt", 5'h0C, 32'hFFFF_FFEF);
    endtask

    initial begin
        #(4 * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        t_reset;
        t_decode;
        t_readonly;
        t_insert_cold;
        t_irq;
        t_eject;
        t_same_cycle;
        t_plat;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule